// File: doc/BRIEF.md
# Compare-Immediate Equality Unit

This unit executes a family of compare-immediate instructions. A 36-bit instruction word is split into four 9-bit fields: opcode, destination, left operand and right operand. A compare writes no register, so the destination field and the left-operand field are free. Together they carry an 18-bit constant. The right-operand field names the register that the constant is tested against. The unit presents that field as a read address. The register file lies outside the unit and returns the register value on an input in the same cycle.

There are four instruction variants. Each widens the 18-bit constant to 36 bits in a different way: the constant in the low half with zeros above it, the constant in the high half with zeros below it, the constant copied into both halves, or the constant in the low half with ones above it. The widened value is checked for equality only. The zero flag is then set on a match and cleared on a mismatch. The other flag bits come straight from the incoming flag word. The new flag word is registered and appears one cycle after the accepted instruction, together with a one-cycle update strobe.

Top module: `cmpi_eq_unit`

## Requirements
- R1: The instruction word is laid out as opcode in bits 35:27, destination in 26:18, left operand in 17:9 and right operand in 8:0. The output `rd_addr` equals bits 8:0 in the same cycle.
- R2: The 18-bit constant has the destination field as bits 17:9 and the left field as bits 8:0.
- R3: Opcode 9'h122 (low form) widens the constant to {18 zeros, constant}.
- R4: Opcode 9'h121 (high form) widens the constant to {constant, 18 zeros}.
- R5: Opcode 9'h120 (both form) widens the constant to {constant, constant}.
- R6: Opcode 9'h123 (negative form) widens the constant to {18 ones, constant}.
- R7: Z is bit 0 of `flags_out`. After an accepted compare it is 1 when the widened constant equals `reg_data`, and 0 otherwise.
- R8: After an accepted compare, bits 3:1 of `flags_out` equal bits 3:1 of `flags_in` from the accepting cycle.
- R9: `flags_out` and `upd_valid` change on the first rising clock edge after an accepted compare. `upd_valid` is high for exactly that one cycle.
- R10: When `in_valid` is low, or the opcode is not one of the four compare opcodes, `flags_out` holds its value and `upd_valid` is low on the next cycle.
- R11: While `rst_n` is low, `flags_out` is 0 and `upd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 36 | Instruction word |
| rd_addr | output | 9 | Register read address (right-operand field) |
| reg_data | input | 36 | Value of the register named by `rd_addr` |
| flags_in | input | 4 | Current flag word |
| flags_out | output | 4 | Registered flag word; bit 0 is Z |
| upd_valid | output | 1 | One-cycle strobe marking a flag update |

## Verification
The assertions assume that `reg_data` is returned in the same cycle as `rd_addr` and that it is stable around the clock edge. They also assume that `flags_in` is the flag word that was current in the accepting cycle. The bench drives every input on the falling edge and holds it through the following rising edge, so these conditions always hold. The stimulus covers each widening form with a value that matches and with a value that differs in exactly one half. It also includes opcodes outside the family and compare opcodes presented with `in_valid` low, so that the hold behaviour is exercised.

// File: rtl/cmpi_pkg.sv
package cmpi_pkg;

   // Widening forms of the 18-bit constant
   typedef enum logic [1:0] {
      CMPV_BOTH = 2'd0,
      CMPV_HIGH = 2'd1,
      CMPV_LOW  = 2'd2,
      CMPV_NEG  = 2'd3
   } cmpi_variant_e;

   localparam int unsigned NUM_VARIANTS = 4;
   localparam int unsigned NUM_FIELDS   = 4;

endpackage

// File: rtl/cmpi_decode.sv
module cmpi_decode
   import cmpi_pkg::*;
#(
   parameter int unsigned FIELD_W  = 9,
   parameter logic [FIELD_W-1:0] OPC_BOTH = 9'h120,
   parameter logic [FIELD_W-1:0] OPC_HIGH = 9'h121,
   parameter logic [FIELD_W-1:0] OPC_LOW  = 9'h122,
   parameter logic [FIELD_W-1:0] OPC_NEG  = 9'h123,
   localparam int unsigned WORD_W = NUM_FIELDS * FIELD_W,
   localparam int unsigned IMM_W  = 2 * FIELD_W
) (
   input  logic [WORD_W-1:0]  instr,
   output logic [FIELD_W-1:0] rd_addr,
   output logic [IMM_W-1:0]   imm,
   output logic               is_cmp,
   output cmpi_variant_e      variant
);

   localparam int unsigned OPC_LSB = 3 * FIELD_W;
   localparam int unsigned DST_LSB = 2 * FIELD_W;
   localparam int unsigned LFT_LSB = FIELD_W;

   if (FIELD_W < 2) begin : g_chk_field
      $error("cmpi_decode: FIELD_W must be at least 2");
   end
   if ((OPC_BOTH == OPC_HIGH) || (OPC_BOTH == OPC_LOW) || (OPC_BOTH == OPC_NEG) ||
       (OPC_HIGH == OPC_LOW) || (OPC_HIGH == OPC_NEG) || (OPC_LOW == OPC_NEG)) begin : g_chk_opc
      $error("cmpi_decode: compare opcodes must be distinct");
   end

   logic [FIELD_W-1:0] opc_f;
   logic [FIELD_W-1:0] dst_f;
   logic [FIELD_W-1:0] lft_f;

   always_comb begin
      opc_f   = instr[OPC_LSB +: FIELD_W];
      dst_f   = instr[DST_LSB +: FIELD_W];
      lft_f   = instr[LFT_LSB +: FIELD_W];
      rd_addr = instr[0 +: FIELD_W];
      imm     = {dst_f, lft_f};
   end

   always_comb begin
      is_cmp  = 1'b1;
      variant = CMPV_BOTH;
      unique case (opc_f)
         OPC_BOTH: variant = CMPV_BOTH;
         OPC_HIGH: variant = CMPV_HIGH;
         OPC_LOW:  variant = CMPV_LOW;
         OPC_NEG:  variant = CMPV_NEG;
         default:  is_cmp  = 1'b0;
      endcase
   end

   // R2: constant halves come from the two borrowed fields
   always_comb begin
      assert_imm_fields_R2: assert (imm == instr[LFT_LSB +: IMM_W])
         else $error("constant is not formed from destination and left fields");
   end

endmodule

// File: rtl/cmpi_expand.sv
module cmpi_expand
   import cmpi_pkg::*;
#(
   parameter int unsigned IMM_W = 18,
   localparam int unsigned WORD_W = 2 * IMM_W
) (
   input  logic [IMM_W-1:0]  imm,
   input  cmpi_variant_e     variant,
   output logic [WORD_W-1:0] wide
);

   if (IMM_W < 1) begin : g_chk_imm
      $error("cmpi_expand: IMM_W must be positive");
   end

   logic [WORD_W-1:0] cand [NUM_VARIANTS];

   for (genvar v = 0; v < NUM_VARIANTS; v++) begin : g_form
      if (v == int'(CMPV_BOTH)) begin : g_both
         assign cand[v] = {imm, imm};
      end else if (v == int'(CMPV_HIGH)) begin : g_high
         assign cand[v] = {imm, {IMM_W{1'b0}}};
      end else if (v == int'(CMPV_LOW)) begin : g_low
         assign cand[v] = {{IMM_W{1'b0}}, imm};
      end else begin : g_neg
         assign cand[v] = {{IMM_W{1'b1}}, imm};
      end
   end

   assign wide = cand[variant];

endmodule

// File: rtl/cmpi_flagreg.sv
module cmpi_flagreg #(
   parameter int unsigned FLAG_W = 4,
   parameter int unsigned Z_BIT  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              z_new,
   input  logic [FLAG_W-1:0] flags_in,
   output logic [FLAG_W-1:0] flags_out,
   output logic              upd_valid
);

   localparam logic [FLAG_W-1:0] ZMASK = {{(FLAG_W-1){1'b0}}, 1'b1} << Z_BIT;

   if (Z_BIT >= FLAG_W) begin : g_chk_z
      $error("cmpi_flagreg: Z_BIT outside flag word");
   end

   logic [FLAG_W-1:0] flags_nxt;

   always_comb begin
      flags_nxt        = flags_in;
      flags_nxt[Z_BIT] = z_new;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_out <= '0;
         upd_valid <= 1'b0;
      end else begin
         upd_valid <= load;
         if (load) begin
            flags_out <= flags_nxt;
         end
      end
   end

   assert_keep_others_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> ((flags_out & ~ZMASK) == ($past(flags_in) & ~ZMASK)))
      else $error("non-zero flags not carried through");

   assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(flags_out) && !upd_valid))
      else $error("flags changed without an accepted compare");

   assert_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> upd_valid)
      else $error("update strobe missing");

endmodule

// File: rtl/cmpi_eq_unit.sv
module cmpi_eq_unit
   import cmpi_pkg::*;
#(
   parameter int unsigned FIELD_W  = 9,
   parameter int unsigned FLAG_W   = 4,
   parameter int unsigned Z_BIT    = 0,
   parameter logic [FIELD_W-1:0] OPC_BOTH = 9'h120,
   parameter logic [FIELD_W-1:0] OPC_HIGH = 9'h121,
   parameter logic [FIELD_W-1:0] OPC_LOW  = 9'h122,
   parameter logic [FIELD_W-1:0] OPC_NEG  = 9'h123,
   localparam int unsigned IMM_W  = 2 * FIELD_W,
   localparam int unsigned WORD_W = NUM_FIELDS * FIELD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [WORD_W-1:0]  instr,
   output logic [FIELD_W-1:0] rd_addr,
   input  logic [WORD_W-1:0]  reg_data,
   input  logic [FLAG_W-1:0]  flags_in,
   output logic [FLAG_W-1:0]  flags_out,
   output logic               upd_valid
);

   logic [IMM_W-1:0]  imm;
   logic              is_cmp;
   cmpi_variant_e     variant;
   logic [WORD_W-1:0] wide;
   logic              match;
   logic              accept;

   cmpi_decode #(
      .FIELD_W  (FIELD_W),
      .OPC_BOTH (OPC_BOTH),
      .OPC_HIGH (OPC_HIGH),
      .OPC_LOW  (OPC_LOW),
      .OPC_NEG  (OPC_NEG)
   ) u_decode (
      .instr   (instr),
      .rd_addr (rd_addr),
      .imm     (imm),
      .is_cmp  (is_cmp),
      .variant (variant)
   );

   cmpi_expand #(
      .IMM_W (IMM_W)
   ) u_expand (
      .imm     (imm),
      .variant (variant),
      .wide    (wide)
   );

   assign match  = (wide == reg_data);
   assign accept = in_valid && is_cmp;

   cmpi_flagreg #(
      .FLAG_W (FLAG_W),
      .Z_BIT  (Z_BIT)
   ) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .z_new     (match),
      .flags_in  (flags_in),
      .flags_out (flags_out),
      .upd_valid (upd_valid)
   );

   assert_low_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && variant == CMPV_LOW && reg_data[WORD_W-1:IMM_W] != '0) |=> !flags_out[Z_BIT])
      else $error("low form matched a value with upper bits set");

   assert_high_lower_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && variant == CMPV_HIGH && reg_data[IMM_W-1:0] != '0) |=> !flags_out[Z_BIT])
      else $error("high form matched a value with lower bits set");

   assert_both_halves_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && variant == CMPV_BOTH && reg_data[WORD_W-1:IMM_W] != reg_data[IMM_W-1:0])
      |=> !flags_out[Z_BIT])
      else $error("both form matched unequal halves");

   assert_neg_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && variant == CMPV_NEG && reg_data[WORD_W-1:IMM_W] != '1) |=> !flags_out[Z_BIT])
      else $error("negative form matched a value without ones above");

   assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (flags_out[Z_BIT] == $past(match)))
      else $error("zero flag disagrees with comparison");

   assert_reset_R11: assert property (@(posedge clk)
      $past(!rst_n) |-> (flags_out == '0 && !upd_valid))
      else $error("reset state wrong");

endmodule

// File: tb/cmpi_eq_unit_tb.sv
`timescale 1ns/1ps
module cmpi_eq_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [35:0] instr;
   logic [8:0]  rd_addr;
   logic [35:0] reg_data;
   logic [3:0]  flags_in;
   logic [3:0]  flags_out;
   logic        upd_valid;

   int checks = 0;
   int errors = 0;
   bit ended  = 1'b0;

   always #10 clk = ~clk;

   cmpi_eq_unit u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .instr     (instr),
      .rd_addr   (rd_addr),
      .reg_data  (reg_data),
      .flags_in  (flags_in),
      .flags_out (flags_out),
      .upd_valid (upd_valid)
   );

   // form select: 0 both (R5), 1 high (R4), 2 low (R3), 3 negative (R6)
   // entry: {form, constant, register, flags_in, expected Z}
   localparam int NV = 12;
   localparam logic [60:0] VEC [0:NV-1] = '{
      {2'd2, 18'h2A5F3, 36'h00002A5F3, 4'hA, 1'b1},
      {2'd2, 18'h2A5F3, 36'h10002A5F3, 4'h4, 1'b0},
      {2'd2, 18'h00000, 36'h000000000, 4'hF, 1'b1},
      {2'd1, 18'h3FFFF, 36'hFFFFC0000, 4'h6, 1'b1},
      {2'd1, 18'h3FFFF, 36'hFFFFC0001, 4'h8, 1'b0},
      {2'd0, 18'h12345, 36'h48D152345, 4'h2, 1'b1},
      {2'd0, 18'h12345, 36'h000012345, 4'hE, 1'b0},
      {2'd0, 18'h12345, 36'h48D140000, 4'h1, 1'b0},
      {2'd3, 18'h00001, 36'hFFFFC0001, 4'hC, 1'b1},
      {2'd3, 18'h00001, 36'h000000001, 4'h3, 1'b0},
      {2'd3, 18'h00000, 36'hFFFFC0000, 4'h0, 1'b1},
      {2'd1, 18'h00000, 36'h000000000, 4'h5, 1'b1}
   };

   function automatic logic [8:0] form_opc(input logic [1:0] f);
      case (f)
         2'd0:    return 9'h120;
         2'd1:    return 9'h121;
         2'd2:    return 9'h122;
         default: return 9'h123;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // present one instruction for one cycle, then sample after the edge
   task automatic issue(input logic vld, input logic [8:0] opc, input logic [17:0] k,
                        input logic [8:0] rsel, input logic [35:0] rv, input logic [3:0] fl);
      @(negedge clk);
      in_valid = vld;
      instr    = {opc, k[17:9], k[8:0], rsel};
      reg_data = rv;
      flags_in = fl;
      #1;
      check(rd_addr == rsel, "R1 rd_addr", {27'd0, rd_addr}, {27'd0, rsel});
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; instr = '0; reg_data = '0; flags_in = '0;
      repeat (3) @(negedge clk);
      check(flags_out == 4'h0 && !upd_valid, "R11 reset", {31'd0, upd_valid, flags_out}, 36'd0);
      rst_n = 1'b1;

      // table walk covering R2..R9
      for (int i = 0; i < NV; i++) begin
         logic [1:0]  f;
         logic [17:0] k;
         logic [35:0] rv;
         logic [3:0]  fl;
         logic        z;
         {f, k, rv, fl, z} = VEC[i];
         issue(1'b1, form_opc(f), k, 9'(i + 7), rv, fl);
         check(flags_out == {fl[3:1], z}, "R7/R8 flags after compare",
               {32'd0, flags_out}, {32'd0, fl[3:1], z});
         check(upd_valid, "R9 strobe", {35'd0, upd_valid}, 36'd1);
         @(negedge clk);
         check(!upd_valid, "R9 single-cycle strobe", {35'd0, upd_valid}, 36'd0);
      end

      // R10: opcode outside family is ignored
      issue(1'b1, 9'h122, 18'h00055, 9'h011, 36'h000000055, 4'hA);
      check(flags_out == 4'hB, "R10 setup", {32'd0, flags_out}, 36'hB);
      issue(1'b1, 9'h124, 18'h00000, 9'h012, 36'h000000001, 4'h4);
      check(flags_out == 4'hB && !upd_valid, "R10 foreign opcode",
            {31'd0, upd_valid, flags_out}, 36'hB);
      // R10: compare opcode with valid low is ignored
      issue(1'b0, 9'h120, 18'h00001, 9'h013, 36'h000000000, 4'h2);
      check(flags_out == 4'hB && !upd_valid, "R10 valid low",
            {31'd0, upd_valid, flags_out}, 36'hB);

      // R2: fields swapped must not match (dest bits are the high half)
      issue(1'b1, 9'h122, {9'h001, 9'h000}, 9'h1FF, 36'h000000001, 4'h0);
      check(flags_out == 4'h0, "R2 field order", {32'd0, flags_out}, 36'h0);
      issue(1'b1, 9'h122, {9'h001, 9'h000}, 9'h1FF, 36'h000000200, 4'h0);
      check(flags_out == 4'h1, "R2 field order match", {32'd0, flags_out}, 36'h1);

      // R3 back-to-back compares update every cycle
      @(negedge clk);
      in_valid = 1'b1; instr = {9'h122, 9'h000, 9'h003, 9'h004};
      reg_data = 36'h3; flags_in = 4'h8;
      @(negedge clk);
      check(flags_out == 4'h9 && upd_valid, "R3 back-to-back first",
            {31'd0, upd_valid, flags_out}, 36'h19);
      reg_data = 36'h4; flags_in = 4'h6;
      @(negedge clk);
      in_valid = 1'b0;
      check(flags_out == 4'h6 && upd_valid, "R3 back-to-back second",
            {31'd0, upd_valid, flags_out}, 36'h16);

      // R11: reset after activity
      rst_n = 1'b0;
      @(negedge clk);
      check(flags_out == 4'h0 && !upd_valid, "R11 reset again",
            {31'd0, upd_valid, flags_out}, 36'd0);
      rst_n = 1'b1;

      if (!ended) begin
         ended = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule